// File: doc/BRIEF.md
# Write-Masked Split GPIO Register Bank

This block is a 32-pin general-purpose I/O register bank attached to a simple 32-bit register bus. Each pin has an output data bit and a direction bit. Both are stored in registers that are split into two words. The lower word holds pins 0 to 15 and the upper word, four bytes higher, holds pins 16 to 31. In every write to a split word, the top sixteen bits act as a per-bit write enable for the bottom sixteen. Software can therefore set or clear any set of pins in one bus write. It needs no read-modify-write sequence and no lock shared between threads.

The bank also holds a read-only input word that returns all 32 pin levels at once. The pin levels pass through a two-stage synchronizer before they reach this word. A constant version word identifies the bank. The output data and direction bits drive the pin output and output-enable vectors straight from flops.

Top module: `gpio_split_bank`

## Requirements
- R1: Pins 0–15 live in the lower word of a split register and pins 16–31 in the word at byte offset +4 from it. A write to one word never changes the pins of the other.
- R2: In a write to a split word, bit n+16 of the write data enables the update of stored bit n (n = 0..15), which then takes write-data bit n. Stored bits whose enable bit is 0 keep their value.
- R3: Output data words are at 0x00 (low) and 0x04 (high) and drive `pin_out`. Direction words are at 0x08 (low) and 0x0C (high) and drive `pin_oe`, where a 1 makes the pin an output. Both vectors change only in the cycle after a write.
- R4: A read of 0x70 returns the 32 pin levels, bit i being pin i, after a two-flop synchronizer. A pin change driven before clock edge k shows in a read sampled at edge k+2, but not in one sampled at edge k+1.
- R5: A read of 0x78 always returns 0x0101157C, and writes to 0x78 change nothing.
- R6: A read of a split word returns its 16 stored bits in bits 15:0 and zero in bits 31:16.
- R7: Synchronous reset clears all output data and direction bits, so every pin starts as an input driving 0.
- R8: Reads of any other address return 0. Writes to any other address, including 0x70, change no stored state.
- R9: Read data appears on `rdata` on the clock edge at which `rd_en` is sampled high, and is visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 8 | Byte address, word aligned |
| wdata | input | 32 | Write data: enables in 31:16, values in 15:0 |
| rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables, 1 = drive |

## Verification
The assertions assume that `addr` is word aligned and that `wr_en` and `rd_en` are not raised together for the same address. They also assume the pin inputs only need to settle through the synchronizer, with no constraint on their timing. The stimulus picks addresses only from a list of aligned mapped and unmapped offsets, and it issues a read or a write alone in each bus cycle. It changes `pin_in` only at falling edges, and it waits the two synchronizer stages before it compares an input read. Random write data exercises every mix of enable and value bits. Directed cases cover all-enable, no-enable, version writes and input-register writes.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned DOUT_OFS   = 32'h00;
  localparam int unsigned DIR_OFS    = 32'h08;
  localparam int unsigned LEVEL_OFS  = 32'h70;
  localparam int unsigned IDENT_OFS  = 32'h78;
  localparam logic [31:0] IDENT_WORD = 32'h0101157C;
  localparam int unsigned WORD_BYTES = 4;
endpackage

// File: rtl/gpio_masked_half.sv
module gpio_masked_half #(
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_sel,
  input  logic [2*HALF_W-1:0]   wdata,
  output logic [HALF_W-1:0]     q
);
  logic [HALF_W-1:0] en_bits;
  logic [HALF_W-1:0] val_bits;

  assign en_bits  = wdata[2*HALF_W-1:HALF_W];
  assign val_bits = wdata[HALF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (wr_sel) begin
      for (int b = 0; b < HALF_W; b++) begin
        if (en_bits[b]) q[b] <= val_bits[b];
      end
    end
  end

  // R2
  keep_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
    wr_sel |=> ((q & ~$past(en_bits)) == ($past(q) & ~$past(en_bits))));

  // R2
  take_masked_chk: assert property (@(posedge clk) disable iff (rst)
    wr_sel |=> ((q & $past(en_bits)) == ($past(val_bits) & $past(en_bits))));

  // R3
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_sel |=> $stable(q));
endmodule

// File: rtl/gpio_level_sync.sv
module gpio_level_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] synced
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      synced <= '0;
    end else begin
      stage1 <= raw;
      synced <= stage1;
    end
  end

  // R4
  second_stage_chk: assert property (@(posedge clk) disable iff (rst)
    ##1 (synced == $past(stage1)));
endmodule

// File: rtl/gpio_split_bank.sv
module gpio_split_bank
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PIN_COUNT = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  input  logic [PIN_COUNT-1:0] pin_in,
  output logic [PIN_COUNT-1:0] pin_out,
  output logic [PIN_COUNT-1:0] pin_oe
);
  localparam int DATA_W     = 32;
  localparam int HALF_W     = DATA_W / 2;
  localparam int NUM_HALVES = PIN_COUNT / HALF_W;
  localparam logic [ADDR_W-1:0] LEVEL_A = ADDR_W'(LEVEL_OFS);
  localparam logic [ADDR_W-1:0] IDENT_A = ADDR_W'(IDENT_OFS);

  logic [HALF_W-1:0]    dout_h [NUM_HALVES];
  logic [HALF_W-1:0]    dir_h  [NUM_HALVES];
  logic [PIN_COUNT-1:0] level_q;
  logic [DATA_W-1:0]    rd_mux;
  logic                 split_hit;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    localparam logic [ADDR_W-1:0] DOUT_A = ADDR_W'(DOUT_OFS + WORD_BYTES * h);
    localparam logic [ADDR_W-1:0] DIR_A  = ADDR_W'(DIR_OFS + WORD_BYTES * h);

    gpio_masked_half #(.HALF_W(HALF_W)) dout_u (
      .clk(clk), .rst(rst),
      .wr_sel(wr_en && (addr == DOUT_A)),
      .wdata(wdata), .q(dout_h[h])
    );

    gpio_masked_half #(.HALF_W(HALF_W)) dir_u (
      .clk(clk), .rst(rst),
      .wr_sel(wr_en && (addr == DIR_A)),
      .wdata(wdata), .q(dir_h[h])
    );

    assign pin_out[h*HALF_W +: HALF_W] = dout_h[h];
    assign pin_oe[h*HALF_W +: HALF_W]  = dir_h[h];
  end

  gpio_level_sync #(.WIDTH(PIN_COUNT)) sync_u (
    .clk(clk), .rst(rst), .raw(pin_in), .synced(level_q)
  );

  always_comb begin
    rd_mux    = '0;
    split_hit = 1'b0;
    for (int h = 0; h < NUM_HALVES; h++) begin
      if (addr == ADDR_W'(DOUT_OFS + WORD_BYTES * h)) begin
        rd_mux    = {{HALF_W{1'b0}}, dout_h[h]};
        split_hit = 1'b1;
      end
      if (addr == ADDR_W'(DIR_OFS + WORD_BYTES * h)) begin
        rd_mux    = {{HALF_W{1'b0}}, dir_h[h]};
        split_hit = 1'b1;
      end
    end
    if (addr == LEVEL_A) rd_mux = DATA_W'(level_q);
    if (addr == IDENT_A) rd_mux = IDENT_WORD;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R5
  ident_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == IDENT_A) |=> (rdata == IDENT_WORD));

  // R6
  split_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && split_hit) |=> (rdata[DATA_W-1:HALF_W] == '0));

  // R8
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !split_hit && addr != LEVEL_A && addr != IDENT_A) |=> (rdata == '0));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/gpio_split_bank_tb_top.sv
module gpio_split_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata, pin_in, pin_out, pin_oe;
  int checks = 0;
  int errors = 0;
  logic [31:0] exp_dout, exp_dir;

  always #5 clk = ~clk;

  gpio_split_bank dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [15:0] masked(input logic [15:0] old, input logic [31:0] w);
    return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  function automatic void model_write(input logic [7:0] a, input logic [31:0] w);
    case (a)
      8'h00: exp_dout[15:0]  = masked(exp_dout[15:0], w);
      8'h04: exp_dout[31:16] = masked(exp_dout[31:16], w);
      8'h08: exp_dir[15:0]   = masked(exp_dir[15:0], w);
      8'h0C: exp_dir[31:16]  = masked(exp_dir[31:16], w);
      default: ;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = w;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, w);
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] r);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    r = rdata;
  endtask

  task automatic check_all_regs(input string tag);
    logic [31:0] r;
    bus_read(8'h00, r); chk({tag, " R6 dout lo"}, r, {16'h0, exp_dout[15:0]});
    bus_read(8'h04, r); chk({tag, " R1 dout hi"}, r, {16'h0, exp_dout[31:16]});
    bus_read(8'h08, r); chk({tag, " R6 dir lo"}, r, {16'h0, exp_dir[15:0]});
    bus_read(8'h0C, r); chk({tag, " R1 dir hi"}, r, {16'h0, exp_dir[31:16]});
    chk({tag, " R3 pin_out"}, pin_out, exp_dout);
    chk({tag, " R3 pin_oe"}, pin_oe, exp_dir);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [7:0] alist [8];
    void'($urandom(32'd4242));
    alist[0] = 8'h00; alist[1] = 8'h04; alist[2] = 8'h08; alist[3] = 8'h0C;
    alist[4] = 8'h70; alist[5] = 8'h78; alist[6] = 8'h10; alist[7] = 8'hFC;
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; pin_in = '0;
    exp_dout = '0; exp_dir = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R7 reset state
    chk("R7 pin_out after reset", pin_out, 32'h0);
    chk("R7 pin_oe after reset", pin_oe, 32'h0);
    check_all_regs("R7 reset");

    // R5 identity word, write ignored
    bus_read(8'h78, r); chk("R5 ident", r, 32'h0101157C);
    bus_write(8'h78, 32'hFFFF_FFFF);
    bus_read(8'h78, r); chk("R5 ident after write", r, 32'h0101157C);

    // R2 all enables, then no enables
    bus_write(8'h00, 32'hFFFF_A5A5);
    chk("R2 full enable", pin_out, 32'h0000_A5A5);
    bus_write(8'h00, 32'h0000_5A5A);
    chk("R2 zero enable keeps", pin_out, 32'h0000_A5A5);
    // R1 high word does not touch low pins
    bus_write(8'h04, 32'hFFFF_1234);
    chk("R1 high word", pin_out, 32'h1234_A5A5);
    // R3 direction
    bus_write(8'h0C, 32'h8000_8000);
    chk("R3 dir pin31 output", pin_oe, 32'h8000_0000);

    // R8 unmapped and input-register writes ignored, unmapped reads zero
    bus_write(8'h70, 32'hFFFF_FFFF);
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_write(8'hFC, 32'hFFFF_0000);
    check_all_regs("R8 after ignored writes");
    bus_read(8'h10, r); chk("R8 unmapped read 0x10", r, 32'h0);
    bus_read(8'hFC, r); chk("R8 unmapped read 0xFC", r, 32'h0);

    // R4 synchronizer latency
    bus_read(8'h70, r); chk("R4 initial levels", r, 32'h0);
    @(negedge clk); pin_in = 32'hDEAD_BEEF;
    rd_en = 1'b1; addr = 8'h70;
    @(negedge clk); rd_en = 1'b0;
    chk("R4 too early shows old", rdata, 32'h0);
    bus_read(8'h70, r); chk("R4 after two stages", r, 32'hDEAD_BEEF);

    // R9 rdata holds without a read
    @(negedge clk); addr = 8'h78;
    @(negedge clk); chk("R9 rdata hold", rdata, 32'hDEAD_BEEF);

    // Random mix R2 R1 R3
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      a = alist[$urandom_range(7)];
      bus_write(a, $urandom);
      chk("R2 random pin_out", pin_out, exp_dout);
      chk("R2 random pin_oe", pin_oe, exp_dir);
      if (i % 50 == 0) check_all_regs("R6 random");
    end

    for (int i = 0; i < 20; i++) begin
      logic [31:0] lv;
      lv = $urandom;
      @(negedge clk); pin_in = lv;
      @(negedge clk);
      bus_read(8'h70, r); chk("R4 random levels", r, lv);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule